// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the combinational control logic that keeps a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) producing correct results without software-inserted no-ops. Every cycle it compares the source register addresses of the decode and execute stages with the destination registers of the younger stages. From these comparisons it drives the select lines of the operand bypass multiplexers. The bypass networks sit in two places: the decode stage, where branch comparison happens, and the execute stage. It also drives a late bypass that hands freshly loaded data to a store sitting in the memory stage.

When a value cannot be bypassed in time, the unit freezes the front of the pipeline. It holds the program counter and the fetch/decode register and turns the decode/execute register into a bubble. This happens when a load result is still in flight, or when a branch in decode needs a result that has not left the execute stage. When a jump or a taken branch resolves in decode, it asks for the instruction just fetched to be replaced by a no-op. The datapath multiplexers and pipeline registers belong to the surrounding pipeline. This unit only decides.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each decode operand select is 2'b01 (take memory-stage result) when the memory stage writes a nonzero register equal to that source and is not a load. Otherwise it is 2'b10 (take write-back result) when the write-back stage writes a nonzero register equal to it. Otherwise it is 2'b00.
- R2: When the memory stage holds a load whose destination equals a decode source, that decode select is 2'b00 even if the write-back stage also matches.
- R3: Each execute operand select is 2'b01 when the memory stage writes a nonzero matching register (load or not), else 2'b10 on a write-back match, else 2'b00. The younger stage wins.
- R4: A source or destination of register 0, or a stage with its write flag clear, never produces a nonzero select, a store bypass or a stall.
- R5: `mem_store_fwd` is 1 exactly when the memory stage is a store and the write-back stage is a load writing the same nonzero register as the store's data register.
- R6: A decode instruction stalls when the execute stage is a load writing a nonzero register that equals its used first source, or its used second source when that source is not store data.
- R7: A store in decode whose data register is loaded by the load in execute does not stall for that register.
- R8: A branch in decode stalls when a used source matches the destination of any writing instruction in execute, or of a load in the memory stage.
- R9: `pc_hold`, `ifid_hold` and `idex_bubble` are always equal and are 1 exactly when R6 or R8 calls for a stall.
- R10: `ifid_flush` is 1 when decode holds a jump, or a branch flagged taken, and no stall is raised. A stall suppresses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | AW | Decode first source register |
| dec_rt | input | AW | Decode second source register |
| dec_rs_used | input | 1 | Decode instruction reads dec_rs |
| dec_rt_used | input | 1 | Decode instruction reads dec_rt |
| dec_is_store | input | 1 | Decode instruction is a store (dec_rt is store data) |
| dec_is_branch | input | 1 | Decode instruction is a conditional branch |
| dec_br_taken | input | 1 | Branch comparison in decode is true |
| dec_is_jump | input | 1 | Decode instruction is an unconditional jump |
| ex_rs | input | AW | Execute first source register |
| ex_rt | input | AW | Execute second source register |
| ex_dst | input | AW | Execute destination register |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rt | input | AW | Memory-stage store data register |
| mem_dst | input | AW | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_store | input | 1 | Memory-stage instruction is a store |
| wb_dst | input | AW | Write-back destination register |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_load | input | 1 | Write-back instruction is a load |
| dec_sel_a | output | 2 | Decode first operand bypass select |
| dec_sel_b | output | 2 | Decode second operand bypass select |
| ex_sel_a | output | 2 | Execute first operand bypass select |
| ex_sel_b | output | 2 | Execute second operand bypass select |
| mem_store_fwd | output | 1 | Use write-back load data as memory-stage store data |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| ifid_flush | output | 1 | Replace the fetched instruction with a no-op |

## Verification
Every output is a pure function of the present stage fields, so each result is due in the same cycle as its stimulus, with no register on the way. The bench therefore sets all stage fields at the falling clock edge and samples the outputs one time unit later. It advances its own pipeline model only after that sample. The model uses the expected stall and flush to decide whether the next cycle shifts, bubbles or squashes, so every later cycle's expectation follows from the previous cycle's checked decision.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int SEL_W = 2;
  typedef logic [SEL_W-1:0] fsel_t;
  localparam fsel_t SEL_NONE = 2'b00;
  localparam fsel_t SEL_MEM  = 2'b01;
  localparam fsel_t SEL_WB   = 2'b10;

  // younger stage wins; a blocked memory-stage hit yields no bypass at all
  function automatic fsel_t pick_sel(input logic mem_hit, input logic mem_block,
                                     input logic wb_hit);
    if (mem_hit)     return mem_block ? SEL_NONE : SEL_MEM;
    else if (wb_hit) return SEL_WB;
    else             return SEL_NONE;
  endfunction
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
(
  input  logic  mem_hit,
  input  logic  mem_block,
  input  logic  wb_hit,
  output fsel_t sel
);
  assign sel = pick_sel(mem_hit, mem_block, wb_hit);

  always_comb begin
    if (mem_hit && !mem_block) begin
      // R3
      mem_priority_chk: assert (sel == SEL_MEM);
    end
  end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl (
  input  logic ex_hit_rs,
  input  logic ex_hit_rt,
  input  logic ex_load,
  input  logic mem_hit_rs,
  input  logic mem_hit_rt,
  input  logic mem_load,
  input  logic rs_used,
  input  logic rt_used,
  input  logic is_store,
  input  logic is_branch,
  input  logic br_taken,
  input  logic is_jump,
  output logic stall,
  output logic flush
);
  logic load_use_stall;
  logic branch_stall;
  logic ctrl_xfer;
  logic rs_late;
  logic rt_late;

  // store data for a store is repaired later by the memory-stage bypass
  assign load_use_stall = ex_load &
                          ((rs_used & ex_hit_rs) | (rt_used & ~is_store & ex_hit_rt));

  assign rs_late      = ex_hit_rs | (mem_hit_rs & mem_load);
  assign rt_late      = ex_hit_rt | (mem_hit_rt & mem_load);
  assign branch_stall = is_branch & ((rs_used & rs_late) | (rt_used & rt_late));

  assign stall     = load_use_stall | branch_stall;
  assign ctrl_xfer = is_jump | (is_branch & br_taken);
  assign flush     = ctrl_xfer & ~stall;

  always_comb begin
    if (is_branch && rs_used && ex_hit_rs) begin
      // R8
      branch_ex_stall_chk: assert (stall);
    end
    if (ex_load && is_store && !rs_used && rt_used && ex_hit_rt && !is_branch) begin
      // R7
      store_after_load_chk: assert (!stall);
    end
  end
endmodule

// File: rtl/hz_store_fwd.sv
module hz_store_fwd (
  input  logic mem_store,
  input  logic wb_load,
  input  logic wb_hit_rt,
  output logic use_wb_data
);
  assign use_wb_data = mem_store & wb_load & wb_hit_rt;
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] dec_rs,
  input  logic [AW-1:0] dec_rt,
  input  logic          dec_rs_used,
  input  logic          dec_rt_used,
  input  logic          dec_is_store,
  input  logic          dec_is_branch,
  input  logic          dec_br_taken,
  input  logic          dec_is_jump,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rt,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic          mem_store,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  input  logic          wb_load,
  output logic [1:0]    dec_sel_a,
  output logic [1:0]    dec_sel_b,
  output logic [1:0]    ex_sel_a,
  output logic [1:0]    ex_sel_b,
  output logic          mem_store_fwd,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          ifid_flush
);
  localparam int NOPS  = 4;
  localparam int NDEC  = 2;

  function automatic logic hits(input logic wen, input logic [AW-1:0] dst,
                                input logic [AW-1:0] src);
    return wen && (dst != '0) && (dst == src);
  endfunction

  logic [AW-1:0] src_addr [NOPS];
  logic [NOPS-1:0] mem_hit;
  logic [NOPS-1:0] wb_hit;
  fsel_t           sel [NOPS];

  assign src_addr[0] = dec_rs;
  assign src_addr[1] = dec_rt;
  assign src_addr[2] = ex_rs;
  assign src_addr[3] = ex_rt;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    assign mem_hit[i] = hits(mem_wen, mem_dst, src_addr[i]);
    assign wb_hit[i]  = hits(wb_wen, wb_dst, src_addr[i]);
    if (i < NDEC) begin : g_dec
      hz_fwd_pick u_pick (
        .mem_hit  (mem_hit[i]),
        .mem_block(mem_load),
        .wb_hit   (wb_hit[i]),
        .sel      (sel[i])
      );
    end else begin : g_ex
      hz_fwd_pick u_pick (
        .mem_hit  (mem_hit[i]),
        .mem_block(1'b0),
        .wb_hit   (wb_hit[i]),
        .sel      (sel[i])
      );
    end
  end

  assign dec_sel_a = sel[0];
  assign dec_sel_b = sel[1];
  assign ex_sel_a  = sel[2];
  assign ex_sel_b  = sel[3];

  logic ex_hit_rs;
  logic ex_hit_rt;
  logic wb_hit_store;
  logic stall;
  logic flush;

  assign ex_hit_rs    = hits(ex_wen, ex_dst, dec_rs);
  assign ex_hit_rt    = hits(ex_wen, ex_dst, dec_rt);
  assign wb_hit_store = hits(wb_wen, wb_dst, mem_rt);

  hz_stall_ctrl u_stall (
    .ex_hit_rs (ex_hit_rs),
    .ex_hit_rt (ex_hit_rt),
    .ex_load   (ex_load),
    .mem_hit_rs(mem_hit[0]),
    .mem_hit_rt(mem_hit[1]),
    .mem_load  (mem_load),
    .rs_used   (dec_rs_used),
    .rt_used   (dec_rt_used),
    .is_store  (dec_is_store),
    .is_branch (dec_is_branch),
    .br_taken  (dec_br_taken),
    .is_jump   (dec_is_jump),
    .stall     (stall),
    .flush     (flush)
  );

  hz_store_fwd u_sfwd (
    .mem_store  (mem_store),
    .wb_load    (wb_load),
    .wb_hit_rt  (wb_hit_store),
    .use_wb_data(mem_store_fwd)
  );

  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  assign ifid_flush  = flush;

  always_comb begin
    if (dec_rs == '0) begin
      // R4
      zero_src_chk: assert (dec_sel_a == SEL_NONE);
    end
    if (dec_sel_a == SEL_MEM || dec_sel_b == SEL_MEM) begin
      // R2
      dec_no_load_mem_chk: assert (!mem_load);
    end
    if (mem_store_fwd) begin
      // R5
      store_fwd_src_chk: assert (wb_load && wb_wen && mem_store && wb_dst != '0);
    end
    if (ifid_flush) begin
      // R10
      flush_vs_hold_chk: assert (!pc_hold && !ifid_hold);
    end
    if (ex_load && ex_wen && ex_dst != '0 && dec_rs_used && dec_rs == ex_dst) begin
      // R6
      load_use_chk: assert (pc_hold && idex_bubble);
    end
  end
endmodule

// File: tb/hazard_fwd_unit_test.sv
module hazard_fwd_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int N_RANDOM = 3000;

  typedef struct packed {
    logic [AW-1:0] rs, rt, dst;
    logic rs_used, rt_used, wen, load, store, branch, taken, jump;
  } stg_t;

  localparam stg_t NOP = '0;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  stg_t d, e, m, w;

  logic [1:0] dec_sel_a, dec_sel_b, ex_sel_a, ex_sel_b;
  logic mem_store_fwd, pc_hold, ifid_hold, idex_bubble, ifid_flush;

  hazard_fwd_unit #(.AW(AW)) uut (
    .dec_rs(d.rs), .dec_rt(d.rt), .dec_rs_used(d.rs_used), .dec_rt_used(d.rt_used),
    .dec_is_store(d.store), .dec_is_branch(d.branch), .dec_br_taken(d.taken),
    .dec_is_jump(d.jump),
    .ex_rs(e.rs), .ex_rt(e.rt), .ex_dst(e.dst), .ex_wen(e.wen), .ex_load(e.load),
    .mem_rt(m.rt), .mem_dst(m.dst), .mem_wen(m.wen), .mem_load(m.load),
    .mem_store(m.store),
    .wb_dst(w.dst), .wb_wen(w.wen), .wb_load(w.load),
    .dec_sel_a(dec_sel_a), .dec_sel_b(dec_sel_b), .ex_sel_a(ex_sel_a),
    .ex_sel_b(ex_sel_b), .mem_store_fwd(mem_store_fwd), .pc_hold(pc_hold),
    .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
  );

  // ---- reference model, written from the requirements ----
  function automatic logic [1:0] want_sel(stg_t mm, stg_t ww, logic [AW-1:0] src,
                                          bit dec_side);
    logic m_match, w_match;
    m_match = (src != 0) && mm.wen && (mm.dst == src);
    w_match = (src != 0) && ww.wen && (ww.dst == src);
    if (m_match) return (dec_side && mm.load) ? 2'b00 : 2'b01;
    return w_match ? 2'b10 : 2'b00;
  endfunction

  function automatic bit want_stall(stg_t dd, stg_t ee, stg_t mm);
    bit ex_ld_rs, ex_ld_rt, br_rs, br_rt;
    bit ex_w_rs, ex_w_rt;
    ex_w_rs  = ee.wen && ee.dst != 0 && ee.dst == dd.rs;
    ex_w_rt  = ee.wen && ee.dst != 0 && ee.dst == dd.rt;
    ex_ld_rs = ee.load && ex_w_rs && dd.rs_used;
    ex_ld_rt = ee.load && ex_w_rt && dd.rt_used && !dd.store;
    br_rs = dd.rs_used && (ex_w_rs || (mm.load && mm.wen && mm.dst != 0 && mm.dst == dd.rs));
    br_rt = dd.rt_used && (ex_w_rt || (mm.load && mm.wen && mm.dst != 0 && mm.dst == dd.rt));
    return ex_ld_rs || ex_ld_rt || (dd.branch && (br_rs || br_rt));
  endfunction

  function automatic bit want_flush(stg_t dd, stg_t ee, stg_t mm);
    if (want_stall(dd, ee, mm)) return 0;
    return dd.jump || (dd.branch && dd.taken);
  endfunction

  function automatic bit want_sfwd(stg_t mm, stg_t ww);
    return mm.store && ww.load && ww.wen && ww.dst != 0 && ww.dst == mm.rt;
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    bit st;
    st = want_stall(d, e, m);
    chk({tag, " R1 dec_sel_a"}, dec_sel_a, want_sel(m, w, d.rs, 1));
    chk({tag, " R1 dec_sel_b"}, dec_sel_b, want_sel(m, w, d.rt, 1));
    chk({tag, " R3 ex_sel_a"}, ex_sel_a, want_sel(m, w, e.rs, 0));
    chk({tag, " R3 ex_sel_b"}, ex_sel_b, want_sel(m, w, e.rt, 0));
    chk({tag, " R5 store_fwd"}, {1'b0, mem_store_fwd}, {1'b0, want_sfwd(m, w)});
    chk({tag, " R9 pc_hold"}, {1'b0, pc_hold}, {1'b0, st});
    chk({tag, " R9 ifid_hold"}, {1'b0, ifid_hold}, {1'b0, st});
    chk({tag, " R9 idex_bubble"}, {1'b0, idex_bubble}, {1'b0, st});
    chk({tag, " R10 flush"}, {1'b0, ifid_flush}, {1'b0, want_flush(d, e, m)});
  endtask

  function automatic stg_t alu(int rd, int s1, int s2);
    stg_t x = NOP;
    x.dst = AW'(rd); x.rs = AW'(s1); x.rt = AW'(s2);
    x.rs_used = 1; x.rt_used = 1; x.wen = 1;
    return x;
  endfunction
  function automatic stg_t lw(int rt, int base);
    stg_t x = NOP;
    x.dst = AW'(rt); x.rt = AW'(rt); x.rs = AW'(base);
    x.rs_used = 1; x.wen = 1; x.load = 1;
    return x;
  endfunction
  function automatic stg_t sw(int rt, int base);
    stg_t x = NOP;
    x.rt = AW'(rt); x.rs = AW'(base);
    x.rs_used = 1; x.rt_used = 1; x.store = 1;
    return x;
  endfunction
  function automatic stg_t beq(int s1, int s2, bit tk);
    stg_t x = NOP;
    x.rs = AW'(s1); x.rt = AW'(s2);
    x.rs_used = 1; x.rt_used = 1; x.branch = 1; x.taken = tk;
    return x;
  endfunction
  function automatic stg_t jmp();
    stg_t x = NOP;
    x.jump = 1;
    return x;
  endfunction

  function automatic stg_t rand_instr();
    int k = $urandom_range(0, 5);
    int a = $urandom_range(0, 3);
    int b = $urandom_range(0, 3);
    int c = $urandom_range(0, 3);
    case (k)
      0, 1: return alu(a, b, c);
      2: return lw(a, b);
      3: return sw(a, b);
      4: return beq(a, b, 1'($urandom_range(0, 1)));
      default: return ($urandom_range(0, 1) != 0) ? jmp() : NOP;
    endcase
  endfunction

  task automatic apply(stg_t dd, stg_t ee, stg_t mm, stg_t ww);
    @(negedge clk);
    d = dd; e = ee; m = mm; w = ww;
    #1;
  endtask

  initial begin
    d = NOP; e = NOP; m = NOP; w = NOP;
    void'($urandom(32'd1234));

    // idle pipeline: all outputs low (R4)
    apply(NOP, NOP, NOP, NOP);
    check_all("R4 idle");
    chk("R4 idle hold", {1'b0, pc_hold}, 2'b00);

    // both younger stages match: memory stage wins (R1, R3)
    apply(alu(1, 2, 3), alu(4, 2, 3), alu(2, 0, 0), alu(2, 0, 0));
    check_all("R1 prio");
    chk("R1 dec_sel_a literal", dec_sel_a, 2'b01);
    chk("R3 ex_sel_a literal", ex_sel_a, 2'b01);

    // matching load in memory stage blocks decode bypass only (R2)
    apply(alu(1, 3, 0), alu(4, 3, 0), lw(3, 0), alu(3, 0, 0));
    check_all("R2 ld");
    chk("R2 dec_sel_a literal", dec_sel_a, 2'b00);
    chk("R2 ex_sel_a literal", ex_sel_a, 2'b01);

    // register 0 and cleared write flag never bypass (R4)
    apply(alu(1, 0, 2), alu(3, 0, 2), alu(0, 0, 0), NOP);
    begin
      stg_t q = alu(2, 0, 0);
      q.wen = 0;
      m = q;
      #1;
    end
    check_all("R4 zero");
    chk("R4 dec_sel_b literal", dec_sel_b, 2'b00);

    // load then dependent store data: no stall (R7); dependent ALU stalls (R6)
    apply(sw(2, 1), lw(2, 3), NOP, NOP);
    check_all("R7 st");
    chk("R7 no stall", {1'b0, pc_hold}, 2'b00);
    apply(alu(5, 2, 0), lw(2, 3), NOP, NOP);
    check_all("R6 lu");
    chk("R6 stall", {1'b0, pc_hold}, 2'b01);

    // taken branch on an execute ALU result: stall, no flush (R8, R10)
    apply(beq(1, 2, 1), alu(2, 0, 0), NOP, NOP);
    check_all("R8 br");
    chk("R8 stall", {1'b0, idex_bubble}, 2'b01);
    chk("R10 suppressed", {1'b0, ifid_flush}, 2'b00);
    // branch on a load in memory stage stalls again
    apply(beq(1, 2, 1), NOP, lw(1, 0), NOP);
    chk("R8 mem load stall", {1'b0, pc_hold}, 2'b01);
    // branch now free: taken branch flushes
    apply(beq(1, 2, 1), NOP, alu(1, 0, 0), NOP);
    chk("R10 taken flush", {1'b0, ifid_flush}, 2'b01);
    chk("R1 branch bypass", dec_sel_a, 2'b01);

    // store in memory stage after load in write-back (R5)
    apply(NOP, NOP, sw(3, 1), lw(3, 0));
    check_all("R5 sf");
    chk("R5 literal", {1'b0, mem_store_fwd}, 2'b01);
    apply(NOP, NOP, sw(3, 1), alu(3, 0, 0));
    chk("R5 alu no fwd", {1'b0, mem_store_fwd}, 2'b00);

    // jump flushes (R10)
    apply(jmp(), NOP, NOP, NOP);
    chk("R10 jump", {1'b0, ifid_flush}, 2'b01);

    // random pipeline model
    d = NOP; e = NOP; m = NOP; w = NOP;
    for (int n = 0; n < N_RANDOM; n++) begin
      bit st, fl;
      @(negedge clk);
      #1;
      check_all("rand");
      st = want_stall(d, e, m);
      fl = want_flush(d, e, m);
      w = m;
      m = e;
      e = st ? NOP : d;
      if (!st) d = fl ? NOP : rand_instr();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule